// File: doc/BRIEF.md
# PCM Time-Slot Channel Assigner

This block ties the time slots of a serial PCM frame to a bank of internal byte channels. Each slot has two independent entries, one for its receive side and one for its transmit side. Each entry names a channel, a channel direction and an enable. Software programs the table indirectly. It first selects a slot number together with a slot direction, then writes or reads the entry of that selected slot. Any channel can be placed on any slot, and the mapping is held per slot.

A slot counter is cleared by a frame-sync pulse and advanced by a byte strobe, so it walks the table once per frame. On every strobe the current slot's receive entry decides where the incoming byte goes, and its transmit entry decides which stored byte goes out. When the entry direction matches the slot direction, the path is the ordinary one: a received byte goes to the channel's receive buffer, and a transmitted byte comes from the channel's transmit register. When the two directions are crossed, the path is turned around. A received byte lands in the transmit register, and a transmit slot plays out the receive buffer. This turned-around path is how two PCM slots are bridged through one shared channel. Serial bit shifting, framing recovery and packet processing belong to the neighbouring blocks.

Top module: `pcm_slot_assigner`

## Requirements
- R1: After reset, `pcm_tx_byte` is 0xFF and every table entry reads back as all zeros (disabled, direction 0, channel 0). The selection is receive side of slot 0, and the slot counter is 0.
- R2: A pulse on `cfg_sel_we` latches `{cfg_sel_slot, cfg_sel_dir}`, where direction 0 means receive and 1 means transmit. A pulse on `cfg_ent_we` writes `{cfg_wr_en, cfg_wr_dir, cfg_wr_chan}` into the selected entry. The read-back outputs show the selected entry one clock after the edge that changed the selection or the entry.
- R3: A `fsync` makes the current slot 0. Each `byte_stb` processes the current slot and then advances the counter by one, wrapping from 31 to 0. When `fsync` and `byte_stb` come in the same cycle, slot 0 is processed.
- R4: A strobe on a slot whose receive entry is enabled with entry direction 0 stores `pcm_rx_byte` in that channel's receive buffer. The buffer is readable on `chan_rx_data` from the following cycle.
- R5: A strobe on a slot whose transmit entry is enabled with entry direction 1 sets `pcm_tx_byte` to the channel's transmit register after that edge. `pcm_tx_byte` changes only on a strobe.
- R6: A disabled transmit entry makes the strobe drive 0xFF. A disabled receive entry leaves every channel buffer unchanged.
- R7: Crossed directions turn the path around. A receive entry with direction 1 writes the byte into the channel's transmit register. A transmit entry with direction 0 sends out the channel's receive buffer, and this is how two PCM slots are bridged.
- R8: When one strobe both writes and sends out the same channel buffer, the output carries the byte stored before that strobe.
- R9: Two transmit slots mapped to the same channel send the same byte.
- R10: The receive entry and the transmit entry of one slot are stored separately. Any channel 0..31 can be placed on any slot 0..31.
- R11: `chan_tx_we` loads `chan_tx_wdata` into the transmit register of channel `chan_idx`. This load takes priority over a crossed-receive write to the same register in the same cycle. `chan_rx_data` and `chan_tx_data` show the two buffers of `chan_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel_we | input | 1 | Latch a new slot selection |
| cfg_sel_slot | input | 5 | Slot number to select |
| cfg_sel_dir | input | 1 | Slot side to select (0 receive, 1 transmit) |
| cfg_ent_we | input | 1 | Write the selected entry |
| cfg_wr_en | input | 1 | Entry enable to write |
| cfg_wr_dir | input | 1 | Entry channel direction to write |
| cfg_wr_chan | input | 5 | Entry channel number to write |
| cfg_rd_en | output | 1 | Read-back enable of selected entry |
| cfg_rd_dir | output | 1 | Read-back direction of selected entry |
| cfg_rd_chan | output | 5 | Read-back channel of selected entry |
| fsync | input | 1 | Frame start, makes current slot 0 |
| byte_stb | input | 1 | Slot strobe, process and advance |
| pcm_rx_byte | input | 8 | Byte received in the current slot |
| pcm_tx_byte | output | 8 | Byte sent in the last processed slot |
| chan_idx | input | 5 | Channel-side access index |
| chan_tx_we | input | 1 | Load a channel transmit register |
| chan_tx_wdata | input | 8 | Byte to load |
| chan_rx_data | output | 8 | Receive buffer of `chan_idx` |
| chan_tx_data | output | 8 | Transmit register of `chan_idx` |

## Verification
The bench targets the following corner cases.
- Read-back latency. A design that read the table one cycle early shows the old entry.
- Side separation. A table that merged the two sides of a slot returns the transmit channel when the receive side is selected.
- Crossed directions. A design that ignored the entry direction would never bridge two PCM slots or fill a transmit register from the line.
- Same-strobe write and send-out. A buffer that forwarded the new byte would emit it in the same slot instead of the old byte.
- Disabled entries. A design that ignored the enable bit would emit channel data instead of 0xFF, or would overwrite a receive buffer.
- Counter wrap after 31 and a frame sync arriving together with a strobe. Either of these misplaces every later slot.

// File: rtl/pcm_asg_pkg.sv
// Package: shared direction encoding for the slot assigner.
// Assumes: receive is 0 and transmit is 1 for both slot and entry sides.
package pcm_asg_pkg;
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } asg_dir_e;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/pcm_slot_counter.sv
// Module: slot counter for one PCM frame.
// Does: gives the slot processed on the current strobe and advances after it.
// Assumes: fsync forces slot 0 for this cycle; counter wraps at NUM_SLOTS-1.
module pcm_slot_counter #(
    parameter int NUM_SLOTS = 32,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              byte_stb,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    // Effective slot for this cycle: frame sync overrides the stored count.
    always_comb begin
        cur_slot = fsync ? '0 : slot_q;
    end

    // Advance after each processed slot, or park on 0 after a lone sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (byte_stb) begin
            slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
        end else if (fsync) begin
            slot_q <= '0;
        end
    end
endmodule

// File: rtl/pcm_slot_table.sv
// Module: per-slot mapping table with indirect register access.
// Does: holds one receive and one transmit entry per slot; a selection
//       register picks the entry for software writes and registered reads;
//       the frame side looks up both entries of the current slot.
// Assumes: entry layout {enable, direction, channel}; reset clears all.
module pcm_slot_table #(
    parameter int NUM_SLOTS = 32,
    parameter int CHAN_W    = 5,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ENT_W    = CHAN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_we,
    input  logic [SLOT_W-1:0] sel_slot,
    input  logic              sel_dir,
    input  logic              ent_we,
    input  logic              wr_en,
    input  logic              wr_dir,
    input  logic [CHAN_W-1:0] wr_chan,
    output logic              rd_en,
    output logic              rd_dir,
    output logic [CHAN_W-1:0] rd_chan,
    input  logic [SLOT_W-1:0] cur_slot,
    output logic              rx_en,
    output logic              rx_dir,
    output logic [CHAN_W-1:0] rx_chan,
    output logic              tx_en,
    output logic              tx_dir,
    output logic [CHAN_W-1:0] tx_chan
);
    import pcm_asg_pkg::*;

    logic [ENT_W-1:0]  rx_tbl [NUM_SLOTS];
    logic [ENT_W-1:0]  tx_tbl [NUM_SLOTS];
    logic [SLOT_W-1:0] sel_slot_q;
    logic              sel_dir_q;
    logic [ENT_W-1:0]  rd_q;

    // Selection register for indirect access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_slot_q <= '0;
            sel_dir_q  <= DIR_RX;
        end else if (sel_we) begin
            sel_slot_q <= sel_slot;
            sel_dir_q  <= sel_dir;
        end
    end

    // Entry storage, written through the selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                rx_tbl[i] <= '0;
                tx_tbl[i] <= '0;
            end
        end else if (ent_we) begin
            if (sel_dir_q == DIR_TX) begin
                tx_tbl[sel_slot_q] <= {wr_en, wr_dir, wr_chan};
            end else begin
                rx_tbl[sel_slot_q] <= {wr_en, wr_dir, wr_chan};
            end
        end
    end

    // Registered read-back of the selected entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= (sel_dir_q == DIR_TX) ? tx_tbl[sel_slot_q] : rx_tbl[sel_slot_q];
        end
    end

    // Unpack read-back and the current slot's two entries.
    always_comb begin
        {rd_en, rd_dir, rd_chan} = rd_q;
        {rx_en, rx_dir, rx_chan} = rx_tbl[cur_slot];
        {tx_en, tx_dir, tx_chan} = tx_tbl[cur_slot];
    end
endmodule

// File: rtl/pcm_switch_buffers.sv
// Module: one-byte receive buffer and transmit register per channel.
// Does: stores received slot bytes, forms the transmitted slot byte, and
//       gives the channel side a load port and read ports.
// Assumes: all reads see values from before the edge (old byte wins);
//          a channel-side load beats a crossed-receive write.
module pcm_switch_buffers #(
    parameter int NUM_CHANS = 32,
    parameter int DATA_W    = 8,
    localparam int CHAN_W   = $clog2(NUM_CHANS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_en,
    input  logic              rx_dir,
    input  logic [CHAN_W-1:0] rx_chan,
    input  logic              tx_en,
    input  logic              tx_dir,
    input  logic [CHAN_W-1:0] tx_chan,
    input  logic [CHAN_W-1:0] host_idx,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rx_data,
    output logic [DATA_W-1:0] host_tx_data,
    output logic [DATA_W-1:0] tx_byte
);
    import pcm_asg_pkg::*;

    logic [DATA_W-1:0] rx_buf [NUM_CHANS];
    logic [DATA_W-1:0] tx_reg [NUM_CHANS];
    logic              line_wr;

    // A receive slot writes only when strobed and enabled.
    always_comb begin
        line_wr = byte_stb && rx_en;
    end

    for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
        // Receive buffer: normal-direction receive slots.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_buf[c] <= '0;
            end else if (line_wr && rx_dir == DIR_RX && rx_chan == CHAN_W'(c)) begin
                rx_buf[c] <= rx_byte;
            end
        end

        // Transmit register: channel-side load first, then crossed receive.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tx_reg[c] <= '0;
            end else if (host_we && host_idx == CHAN_W'(c)) begin
                tx_reg[c] <= host_wdata;
            end else if (line_wr && rx_dir == DIR_TX && rx_chan == CHAN_W'(c)) begin
                tx_reg[c] <= rx_byte;
            end
        end
    end

    // Outgoing slot byte: idle when disabled, else the chosen buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= DATA_W'(IDLE_BYTE);
        end else if (byte_stb) begin
            if (!tx_en) begin
                tx_byte <= DATA_W'(IDLE_BYTE);
            end else if (tx_dir == DIR_TX) begin
                tx_byte <= tx_reg[tx_chan];
            end else begin
                tx_byte <= rx_buf[tx_chan];
            end
        end
    end

    // Channel-side read ports.
    always_comb begin
        host_rx_data = rx_buf[host_idx];
        host_tx_data = tx_reg[host_idx];
    end
endmodule

// File: rtl/pcm_slot_assigner.sv
// Module: PCM time-slot channel assigner (top).
// Does: joins the slot counter, the mapping table and the channel buffers.
// Assumes: one strobe per slot, all inputs synchronous to clk.
module pcm_slot_assigner #(
    parameter int NUM_SLOTS = 32,
    parameter int NUM_CHANS = 32,
    parameter int DATA_W    = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int CHAN_W   = $clog2(NUM_CHANS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel_we,
    input  logic [SLOT_W-1:0] cfg_sel_slot,
    input  logic              cfg_sel_dir,
    input  logic              cfg_ent_we,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_dir,
    input  logic [CHAN_W-1:0] cfg_wr_chan,
    output logic              cfg_rd_en,
    output logic              cfg_rd_dir,
    output logic [CHAN_W-1:0] cfg_rd_chan,
    input  logic              fsync,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] pcm_rx_byte,
    output logic [DATA_W-1:0] pcm_tx_byte,
    input  logic [CHAN_W-1:0] chan_idx,
    input  logic              chan_tx_we,
    input  logic [DATA_W-1:0] chan_tx_wdata,
    output logic [DATA_W-1:0] chan_rx_data,
    output logic [DATA_W-1:0] chan_tx_data
);
    logic [SLOT_W-1:0] cur_slot;
    logic [SLOT_W-1:0] slot_q;
    logic              rx_en, rx_dir, tx_en, tx_dir;
    logic [CHAN_W-1:0] rx_chan, tx_chan;

    pcm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .byte_stb (byte_stb),
        .cur_slot (cur_slot),
        .slot_q   (slot_q)
    );

    pcm_slot_table #(.NUM_SLOTS(NUM_SLOTS), .CHAN_W(CHAN_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_we   (cfg_sel_we),
        .sel_slot (cfg_sel_slot),
        .sel_dir  (cfg_sel_dir),
        .ent_we   (cfg_ent_we),
        .wr_en    (cfg_wr_en),
        .wr_dir   (cfg_wr_dir),
        .wr_chan  (cfg_wr_chan),
        .rd_en    (cfg_rd_en),
        .rd_dir   (cfg_rd_dir),
        .rd_chan  (cfg_rd_chan),
        .cur_slot (cur_slot),
        .rx_en    (rx_en),
        .rx_dir   (rx_dir),
        .rx_chan  (rx_chan),
        .tx_en    (tx_en),
        .tx_dir   (tx_dir),
        .tx_chan  (tx_chan)
    );

    pcm_switch_buffers #(.NUM_CHANS(NUM_CHANS), .DATA_W(DATA_W)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_stb     (byte_stb),
        .rx_byte      (pcm_rx_byte),
        .rx_en        (rx_en),
        .rx_dir       (rx_dir),
        .rx_chan      (rx_chan),
        .tx_en        (tx_en),
        .tx_dir       (tx_dir),
        .tx_chan      (tx_chan),
        .host_idx     (chan_idx),
        .host_we      (chan_tx_we),
        .host_wdata   (chan_tx_wdata),
        .host_rx_data (chan_rx_data),
        .host_tx_data (chan_tx_data),
        .tx_byte      (pcm_tx_byte)
    );
endmodule

// File: rtl/pcm_slot_assigner_chk.sv
// Module: property checker for the slot assigner, bound to the top.
// Does: watches the counter, read-back timing and the transmit byte.
// Assumes: synchronous active-low reset; all properties disabled in reset.
module pcm_slot_assigner_chk #(
    parameter int SLOT_W = 5,
    parameter int CHAN_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fsync,
    input logic              byte_stb,
    input logic [SLOT_W-1:0] slot_q,
    input logic              tx_en,
    input logic [DATA_W-1:0] pcm_tx_byte,
    input logic              cfg_sel_we,
    input logic              cfg_ent_we,
    input logic              cfg_wr_en,
    input logic              cfg_wr_dir,
    input logic [CHAN_W-1:0] cfg_wr_chan,
    input logic              cfg_rd_en,
    input logic              cfg_rd_dir,
    input logic [CHAN_W-1:0] cfg_rd_chan
);
    localparam logic [SLOT_W-1:0] LAST = '1;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !fsync && slot_q == LAST) |=> (slot_q == '0)); // R3

    AST_SYNC_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && !byte_stb) |=> (slot_q == '0)); // R3

    AST_SYNC_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && byte_stb) |=> (slot_q == SLOT_W'(1))); // R3

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(pcm_tx_byte)); // R5

    AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !tx_en) |=> (pcm_tx_byte == '1)); // R6

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ent_we && !cfg_sel_we) ##1 !cfg_sel_we |=>
        (cfg_rd_chan == $past(cfg_wr_chan, 2) && cfg_rd_dir == $past(cfg_wr_dir, 2)
         && cfg_rd_en == $past(cfg_wr_en, 2))); // R2
endmodule

bind pcm_slot_assigner pcm_slot_assigner_chk #(
    .SLOT_W(SLOT_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .byte_stb    (byte_stb),
    .slot_q      (slot_q),
    .tx_en       (tx_en),
    .pcm_tx_byte (pcm_tx_byte),
    .cfg_sel_we  (cfg_sel_we),
    .cfg_ent_we  (cfg_ent_we),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_dir  (cfg_wr_dir),
    .cfg_wr_chan (cfg_wr_chan),
    .cfg_rd_en   (cfg_rd_en),
    .cfg_rd_dir  (cfg_rd_dir),
    .cfg_rd_chan (cfg_rd_chan)
);

// File: tb/sim_pcm_slot_assigner.sv
// Bench: directed scenarios for the slot assigner, one task per scenario.
module sim_pcm_slot_assigner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_sel_we = 1'b0, cfg_sel_dir = 1'b0, cfg_ent_we = 1'b0;
    logic [4:0] cfg_sel_slot = '0, cfg_wr_chan = '0;
    logic       cfg_wr_en = 1'b0, cfg_wr_dir = 1'b0;
    logic       cfg_rd_en, cfg_rd_dir;
    logic [4:0] cfg_rd_chan;
    logic       fsync = 1'b0, byte_stb = 1'b0;
    logic [7:0] pcm_rx_byte = '0, pcm_tx_byte;
    logic [4:0] chan_idx = '0;
    logic       chan_tx_we = 1'b0;
    logic [7:0] chan_tx_wdata = '0, chan_rx_data, chan_tx_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    pcm_slot_assigner u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic select(input logic [4:0] slot, input logic dir);
        cfg_sel_slot = slot; cfg_sel_dir = dir; cfg_sel_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_sel_we = 1'b0;
    endtask

    task automatic set_entry(input logic [4:0] slot, input logic dir,
                             input logic en, input logic edir, input logic [4:0] ch);
        select(slot, dir);
        cfg_wr_en = en; cfg_wr_dir = edir; cfg_wr_chan = ch; cfg_ent_we = 1'b1;
        @(posedge clk); @(negedge clk);
        cfg_ent_we = 1'b0;
    endtask

    task automatic load_tx(input logic [4:0] ch, input logic [7:0] b);
        chan_idx = ch; chan_tx_wdata = b; chan_tx_we = 1'b1;
        @(posedge clk); @(negedge clk);
        chan_tx_we = 1'b0;
    endtask

    task automatic step(input logic [7:0] b);
        pcm_rx_byte = b; byte_stb = 1'b1;
        @(posedge clk); @(negedge clk);
        byte_stb = 1'b0; pcm_rx_byte = '0;
    endtask

    // Lone frame sync, then strobe n slots with zero data.
    task automatic run_to(input int n);
        fsync = 1'b1;
        @(posedge clk); @(negedge clk);
        fsync = 1'b0;
        for (int i = 0; i < n; i++) step(8'h00);
    endtask

    task automatic t_reset;
        check("R1 tx idle", pcm_tx_byte, 8'hFF);
        check("R1 readback zero", {cfg_rd_en, cfg_rd_dir, cfg_rd_chan}, 7'h00);
        step(8'h11); // counter at 0, all entries disabled
        check("R1 disabled after reset", pcm_tx_byte, 8'hFF);
    endtask

    task automatic t_config;
        set_entry(5'd3, 1'b0, 1'b1, 1'b0, 5'd7);
        set_entry(5'd3, 1'b1, 1'b1, 1'b1, 5'd9);
        @(negedge clk);
        check("R2 readback tx side", {cfg_rd_en, cfg_rd_dir, cfg_rd_chan}, {2'b11, 5'd9});
        select(5'd3, 1'b0);
        @(negedge clk);
        check("R10 readback rx side", {cfg_rd_en, cfg_rd_dir, cfg_rd_chan}, {2'b10, 5'd7});
        select(5'd31, 1'b1);
        @(negedge clk);
        check("R2 other slot zero", {cfg_rd_en, cfg_rd_dir, cfg_rd_chan}, 7'h00);
    endtask

    task automatic t_normal;
        load_tx(5'd9, 8'hA5);
        check("R11 tx load", chan_tx_data, 8'hA5);
        set_entry(5'd4, 1'b0, 1'b0, 1'b0, 5'd7); // disabled rx on slot 4
        run_to(3);
        check("R6 disabled tx slot", pcm_tx_byte, 8'hFF);
        step(8'h3C); // slot 3
        check("R5 tx from channel", pcm_tx_byte, 8'hA5);
        chan_idx = 5'd7;
        #0;
        check("R4 rx stored", chan_rx_data, 8'h3C);
        step(8'h99); // slot 4 disabled
        check("R6 disabled rx ignored", chan_rx_data, 8'h3C);
    endtask

    task automatic t_wrap;
        run_to(35); // slots 0..31 then 0,1,2
        step(8'h00); // slot 3 again
        check("R3 wrap to slot 3", pcm_tx_byte, 8'hA5);
        for (int i = 0; i < 5; i++) step(8'h00);
        fsync = 1'b1; // sync together with strobe: slot 0
        step(8'h00);
        fsync = 1'b0;
        step(8'h00); step(8'h00);
        step(8'h00); // slot 3
        check("R3 sync with strobe", pcm_tx_byte, 8'hA5);
    endtask

    task automatic t_loopback;
        set_entry(5'd10, 1'b0, 1'b1, 1'b0, 5'd12);
        set_entry(5'd12, 1'b0, 1'b1, 1'b0, 5'd12);
        set_entry(5'd12, 1'b1, 1'b1, 1'b0, 5'd12);
        set_entry(5'd20, 1'b1, 1'b1, 1'b0, 5'd12);
        run_to(10);
        step(8'h5A); // slot 10
        step(8'h00); // slot 11
        step(8'h77); // slot 12 writes and sends channel 12
        check("R8 old byte out", pcm_tx_byte, 8'h5A);
        chan_idx = 5'd12;
        #0;
        check("R8 new byte stored", chan_rx_data, 8'h77);
        for (int i = 13; i < 20; i++) step(8'h00);
        step(8'h00); // slot 20
        check("R7 slot bridge", pcm_tx_byte, 8'h77);
    endtask

    task automatic t_crossed_rx;
        set_entry(5'd6, 1'b0, 1'b1, 1'b1, 5'd2);
        run_to(6);
        step(8'hC3);
        chan_idx = 5'd2;
        #0;
        check("R7 crossed rx to tx reg", chan_tx_data, 8'hC3);
        check("R7 rx buf untouched", chan_rx_data, 8'h00);
    endtask

    task automatic t_dual_tx;
        set_entry(5'd25, 1'b1, 1'b1, 1'b1, 5'd9);
        set_entry(5'd26, 1'b1, 1'b1, 1'b1, 5'd9);
        run_to(25);
        step(8'h00);
        check("R9 first slot", pcm_tx_byte, 8'hA5);
        step(8'h00);
        check("R9 second slot", pcm_tx_byte, 8'hA5);
    endtask

    task automatic t_priority;
        run_to(6);
        chan_idx = 5'd2; chan_tx_wdata = 8'h42; chan_tx_we = 1'b1;
        step(8'hEE); // crossed write to channel 2 in the same cycle
        chan_tx_we = 1'b0;
        check("R11 host load wins", chan_tx_data, 8'h42);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_normal;
        t_wrap;
        t_loopback;
        t_crossed_rx;
        t_dual_tx;
        t_priority;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule